// File: doc/BRIEF.md
# Paged Aperture Address Translator

This block keeps a small page table in on-chip memory and turns 32-bit aperture offsets into physical bus addresses at 4 KiB granularity. Table words 0 and 1 form an object header: a descriptor word and the aperture limit. The translation entries follow, so the entry for aperture page `p` lives at table word `p + 2`. After reset a walker writes both header words and clears every entry. Only then does it accept host commands.

A host command binds or unbinds a run of host pages. A host page spans `2**SUB_LOG2` table entries. A bind stores the 4 KiB-aligned physical base with both access bits set, and the address steps by 4 KiB for each following entry. An unbind writes zeros over the run. The walker writes one table word per cycle.

The lookup port is independent of the command port. It takes an offset, or in raw mode a table word index. One cycle later it returns the result with a valid strobe and a fault flag.

Top module: `aperture_xlat`

## Requirements
- R1: After reset `cmd_ready` stays low for exactly `NUM_ENTRIES+2` cycles while the walker writes the header and then zero into every entry word. After that it is high, and raw reads of entry words return 0.
- R2: Table word 0 holds the descriptor. Bits 11:0 are the object class (default 0x03D). Bit 12 is 1, meaning the page table is present. Bit 13 is 0, meaning not linear. Bit 14 is 0, meaning read/write. Bits 17:16 are 2, meaning system bus. The default value is 0x0002103D.
- R3: Table word 1 holds the aperture size minus one, which is `NUM_ENTRIES*4096-1` (0x3FFFF by default).
- R4: A bind of host page `h`, count `c` and physical address `a` writes entry words `(h<<SUB_LOG2)+2+k` for k = 0 .. `(c<<SUB_LOG2)-1`. Each word is `(a & ~0xFFF) + k*4096` with bits 1:0 set to 3. The low 12 bits of `a` are ignored.
- R5: An unbind writes 0 over the same run. Entries outside the run keep their values. Unbinding entries that were never bound leaves them at 0.
- R6: A translate lookup returns `(entry & ~0xFFF) | (offset & 0xFFF)`, where the entry is table word `(offset>>12)+2`.
- R7: A translate lookup faults and returns 0 when the offset exceeds the limit or when bit 0 of the entry is 0.
- R8: A raw lookup (`lk_raw`=1) returns table word `lk_addr` unchanged. It faults and returns 0 when `lk_addr >= NUM_ENTRIES+2`.
- R9: `rd_valid` rises exactly one cycle after `lk_valid`. When `rd_valid` is low, `rd_data` and `rd_fault` are 0.
- R10: A lookup of a word in the same cycle that word is written returns the old contents.
- R11: An accepted command keeps `cmd_ready` low for exactly as many cycles as it writes entries. A run is clipped at the end of the table. A count of 0, or a start beyond the table, writes nothing and leaves `cmd_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is high |
| cmd_unbind | input | 1 | 1 = unbind (clear), 0 = bind |
| cmd_page | input | ADDR_W-PAGE_SHIFT-SUB_LOG2 | First host page of the run |
| cmd_count | input | CNT_W | Number of host pages |
| cmd_phys | input | ADDR_W | Physical base of the run (bind only) |
| cmd_ready | output | 1 | Walker idle, command can be taken |
| lk_valid | input | 1 | Lookup request |
| lk_raw | input | 1 | 1 = read table word `lk_addr`, 0 = translate offset |
| lk_addr | input | ADDR_W | Aperture offset or word index |
| rd_valid | output | 1 | Lookup result strobe |
| rd_data | output | ADDR_W | Translated address or table word, 0 on fault |
| rd_fault | output | 1 | Lookup faulted |

## Verification
The properties assume that every input holds a known value once reset is released. They also assume `cmd_page`, `cmd_count` and `lk_addr` are only acted on in the cycle their strobe is high. Reset itself is synchronous, so properties are disabled while it is asserted. The stimulus drives inputs on the falling edge only, lowers each strobe after one cycle, and offers commands only after it has seen `cmd_ready` high. It issues no lookups until the header and clearing pass has finished, because table contents are undefined before then.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned HDR_WORDS      = 2;
  localparam int unsigned PT_PRESENT_BIT = 12;
  localparam int unsigned LINEAR_BIT     = 13;
  localparam int unsigned ACCESS_BIT     = 14;
  localparam int unsigned TARGET_LSB     = 16;
  localparam logic [1:0]  TARGET_SYSBUS  = 2'd2;
  localparam logic [1:0]  ENTRY_ACC      = 2'b11;

  typedef enum logic [1:0] {
    W_INIT = 2'd0,
    W_IDLE = 2'd1,
    W_RUN  = 2'd2
  } walk_state_t;

  // Object descriptor: class in the low bits, page table present,
  // non-linear, read/write access, system-bus target.
  function automatic logic [31:0] make_desc(input logic [11:0] cls);
    logic [31:0] d;
    d = {20'd0, cls};
    d[PT_PRESENT_BIT]          = 1'b1;
    d[LINEAR_BIT]              = 1'b0;
    d[ACCESS_BIT]              = 1'b0;
    d[TARGET_LSB +: 2]         = TARGET_SYSBUS;
    return d;
  endfunction

endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int DW    = 32,
  parameter int DEPTH = 66,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  // Read-first: a read of the word being written returns the old value.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          PAGE_SHIFT  = 12,
  parameter int          SUB_LOG2    = 1,
  parameter int          NUM_ENTRIES = 64,
  parameter int          CNT_W       = 8,
  parameter logic [11:0] OBJ_CLASS   = 12'h03D,
  localparam int HPG_W  = ADDR_W - PAGE_SHIFT - SUB_LOG2,
  localparam int DEPTH  = NUM_ENTRIES + HDR_WORDS,
  localparam int WIDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_unbind,
  input  logic [HPG_W-1:0]  cmd_page,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_phys,
  output logic              cmd_ready,
  output logic              we,
  output logic [WIDX_W-1:0] waddr,
  output logic [ADDR_W-1:0] wdata
);

  localparam int RUN_W = $clog2(NUM_ENTRIES + 1);
  localparam int CMPW  = ADDR_W + CNT_W + 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'((NUM_ENTRIES << PAGE_SHIFT) - 1);
  localparam logic [ADDR_W-1:0] DESC  = ADDR_W'(make_desc(OBJ_CLASS));
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1) << PAGE_SHIFT;

  walk_state_t       st;
  logic [WIDX_W-1:0] ptr;
  logic [RUN_W-1:0]  left;
  logic [ADDR_W-1:0] data;
  logic              unb;

  logic [CMPW-1:0] s_w, want_w, room_w, len_w;
  logic            unused_phys_lo;

  assign unused_phys_lo = ^cmd_phys[PAGE_SHIFT-1:0];

  // Clip the requested run at the end of the table.
  always_comb begin
    s_w    = CMPW'(cmd_page) << SUB_LOG2;
    want_w = CMPW'(cmd_count) << SUB_LOG2;
    room_w = '0;
    len_w  = '0;
    if (s_w < CMPW'(NUM_ENTRIES)) begin
      room_w = CMPW'(NUM_ENTRIES) - s_w;
      len_w  = (want_w < room_w) ? want_w : room_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= W_INIT;
      ptr  <= '0;
      left <= '0;
      data <= '0;
      unb  <= 1'b0;
    end else begin
      case (st)
        W_INIT: begin
          if (ptr == WIDX_W'(DEPTH - 1)) st <= W_IDLE;
          else                           ptr <= ptr + 1'b1;
        end
        W_IDLE: begin
          if (cmd_valid && len_w != '0) begin
            st   <= W_RUN;
            ptr  <= WIDX_W'(s_w + CMPW'(HDR_WORDS));
            left <= RUN_W'(len_w);
            data <= {cmd_phys[ADDR_W-1:PAGE_SHIFT], PAGE_SHIFT'(ENTRY_ACC)};
            unb  <= cmd_unbind;
          end
        end
        W_RUN: begin
          ptr  <= ptr + 1'b1;
          data <= data + STEP;
          left <= left - 1'b1;
          if (left == RUN_W'(1)) st <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == W_IDLE);
  assign we        = (st != W_IDLE);
  assign waddr     = ptr;

  always_comb begin
    if (st == W_INIT) begin
      if (ptr == WIDX_W'(0))      wdata = DESC;
      else if (ptr == WIDX_W'(1)) wdata = LIMIT;
      else                        wdata = '0;
    end else begin
      wdata = unb ? '0 : data;
    end
  end

endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int NUM_ENTRIES = 64,
  localparam int DEPTH  = NUM_ENTRIES + HDR_WORDS,
  localparam int WIDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic              lk_raw,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              re,
  output logic [WIDX_W-1:0] raddr,
  input  logic [ADDR_W-1:0] q,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_fault
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'((NUM_ENTRIES << PAGE_SHIFT) - 1);

  logic                  in_aper, raw_ok, oor;
  logic                  v_q, raw_q, oor_q;
  logic [PAGE_SHIFT-1:0] lo_q;
  logic                  flt;

  assign in_aper = (lk_addr <= LIMIT);
  assign raw_ok  = (lk_addr < ADDR_W'(DEPTH));
  assign oor     = lk_raw ? !raw_ok : !in_aper;
  assign re      = lk_valid;

  always_comb begin
    if (lk_raw)       raddr = raw_ok ? WIDX_W'(lk_addr) : '0;
    else if (in_aper) raddr = WIDX_W'(lk_addr >> PAGE_SHIFT) + WIDX_W'(HDR_WORDS);
    else              raddr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      raw_q <= 1'b0;
      oor_q <= 1'b0;
      lo_q  <= '0;
    end else begin
      v_q <= lk_valid;
      if (lk_valid) begin
        raw_q <= lk_raw;
        oor_q <= oor;
        lo_q  <= lk_addr[PAGE_SHIFT-1:0];
      end
    end
  end

  assign flt      = v_q && (oor_q || (!raw_q && !q[0]));
  assign rd_valid = v_q;
  assign rd_fault = flt;

  always_comb begin
    if (!v_q || flt) rd_data = '0;
    else if (raw_q)  rd_data = q;
    else             rd_data = {q[ADDR_W-1:PAGE_SHIFT], lo_q};
  end

endmodule

// File: rtl/aperture_xlat.sv
module aperture_xlat
  import xlat_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          PAGE_SHIFT  = 12,
  parameter int          SUB_LOG2    = 1,
  parameter int          NUM_ENTRIES = 64,
  parameter int          CNT_W       = 8,
  parameter logic [11:0] OBJ_CLASS   = 12'h03D,
  localparam int HPG_W  = ADDR_W - PAGE_SHIFT - SUB_LOG2,
  localparam int DEPTH  = NUM_ENTRIES + HDR_WORDS,
  localparam int WIDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_unbind,
  input  logic [HPG_W-1:0]  cmd_page,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [ADDR_W-1:0] cmd_phys,
  output logic              cmd_ready,
  input  logic              lk_valid,
  input  logic              lk_raw,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_fault
);

  logic              t_we, t_re;
  logic [WIDX_W-1:0] t_waddr, t_raddr;
  logic [ADDR_W-1:0] t_wdata, t_q;

  xlat_walker #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SUB_LOG2(SUB_LOG2),
    .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W), .OBJ_CLASS(OBJ_CLASS)
  ) u_walker (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_unbind(cmd_unbind), .cmd_page(cmd_page),
    .cmd_count(cmd_count), .cmd_phys(cmd_phys), .cmd_ready(cmd_ready),
    .we(t_we), .waddr(t_waddr), .wdata(t_wdata)
  );

  xlat_table #(.DW(ADDR_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .we(t_we), .waddr(t_waddr), .wdata(t_wdata),
    .re(t_re), .raddr(t_raddr), .q(t_q)
  );

  xlat_lookup #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_lookup (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_raw(lk_raw), .lk_addr(lk_addr),
    .re(t_re), .raddr(t_raddr), .q(t_q),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault)
  );

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int SUB_LOG2    = 1,
  parameter int NUM_ENTRIES = 64,
  parameter int CNT_W       = 8,
  localparam int HPG_W = ADDR_W - PAGE_SHIFT - SUB_LOG2,
  localparam int CW    = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [HPG_W-1:0]  cmd_page,
  input logic [CNT_W-1:0]  cmd_count,
  input logic              cmd_ready,
  input logic              lk_valid,
  input logic              lk_raw,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_data,
  input logic              rd_fault
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'((NUM_ENTRIES << PAGE_SHIFT) - 1);
  localparam logic [ADDR_W-1:0] DEPTH = ADDR_W'(NUM_ENTRIES + 2);

  logic start_ok;
  assign start_ok = ((CW'(cmd_page) << SUB_LOG2) < CW'(NUM_ENTRIES));

  assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rd_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rd_valid && !rd_fault && rd_data == '0));

  assert_fault_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rd_fault |-> rd_data == '0);

  assert_over_limit_R7: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_raw && lk_addr > LIMIT) |=> rd_fault);

  assert_raw_range_R8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_raw && lk_addr >= DEPTH) |=> rd_fault);

  assert_offset_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_raw) |=>
      (rd_fault || rd_data[PAGE_SHIFT-1:0] == $past(lk_addr[PAGE_SHIFT-1:0])));

  assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_count != '0 && start_ok) |=> !cmd_ready);

endmodule

bind aperture_xlat xlat_checker #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SUB_LOG2(SUB_LOG2),
  .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)
) u_xlat_checker (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_page(cmd_page),
  .cmd_count(cmd_count), .cmd_ready(cmd_ready), .lk_valid(lk_valid),
  .lk_raw(lk_raw), .lk_addr(lk_addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_fault(rd_fault)
);

// File: tb/test_aperture_xlat.sv
module test_aperture_xlat;

  localparam int NE    = 64;
  localparam int DEPTH = NE + 2;
  localparam int SUBN  = 2;
  localparam logic [31:0] DESC_EXP = 32'h0002_103D;
  localparam logic [31:0] LIM_EXP  = 32'h0003_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_unbind = 1'b0;
  logic [18:0] cmd_page = '0;
  logic [7:0]  cmd_count = '0;
  logic [31:0] cmd_phys = '0;
  logic        cmd_ready;
  logic        lk_valid = 1'b0, lk_raw = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rd_valid, rd_fault;
  logic [31:0] rd_data;

  aperture_xlat i_aperture_xlat (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_unbind(cmd_unbind),
    .cmd_page(cmd_page), .cmd_count(cmd_count), .cmd_phys(cmd_phys),
    .cmd_ready(cmd_ready), .lk_valid(lk_valid), .lk_raw(lk_raw),
    .lk_addr(lk_addr), .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault)
  );

  always #10 clk = ~clk;

  int    n_tests = 0, n_fail = 0;
  bit    done = 0, live = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [31:0] m_mem [DEPTH];
  bit          m_init;
  int          m_ptr, m_left, m_word, s_i, w_i;
  logic [31:0] m_data;
  bit          m_unb;
  bit          e_valid, e_fault;
  logic [31:0] e_data;
  string       e_tag = "R9";

  always @(posedge clk) begin
    if (rst) begin
      m_init = 1; m_ptr = 0; m_left = 0;
      e_valid = 0; e_fault = 0; e_data = 0;
    end else begin
      e_tag = cur_req;
      if (!lk_valid) begin
        e_valid = 0; e_fault = 0; e_data = 0;
      end else begin
        e_valid = 1;
        if (lk_raw) begin
          if (lk_addr < DEPTH) begin e_data = m_mem[lk_addr]; e_fault = 0; end
          else begin e_data = 0; e_fault = 1; end
        end else if (lk_addr > LIM_EXP || m_mem[(lk_addr >> 12) + 2][0] == 1'b0) begin
          e_data = 0; e_fault = 1;
        end else begin
          e_data = {m_mem[(lk_addr >> 12) + 2][31:12], lk_addr[11:0]}; e_fault = 0;
        end
      end
      if (m_init) begin
        m_mem[m_ptr] = (m_ptr == 0) ? DESC_EXP : (m_ptr == 1) ? LIM_EXP : 32'h0;
        if (m_ptr == DEPTH - 1) m_init = 0; else m_ptr++;
      end else if (m_left > 0) begin
        m_mem[m_word] = m_unb ? 32'h0 : m_data;
        m_word++; m_data += 32'h1000; m_left--;
      end else if (cmd_valid) begin
        s_i = int'(cmd_page) * SUBN;
        w_i = int'(cmd_count) * SUBN;
        if (s_i < NE) begin
          m_left = (w_i < NE - s_i) ? w_i : NE - s_i;
          m_word = s_i + 2;
          m_data = {cmd_phys[31:12], 12'h003};
          m_unb  = cmd_unbind;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare outputs against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk(cmd_ready === (!m_init && m_left == 0), (m_init ? "R1" : cur_req),
          "cmd_ready", 32'(cmd_ready), 32'(!m_init && m_left == 0));
      chk(rd_valid === e_valid, e_tag, "rd_valid", 32'(rd_valid), 32'(e_valid));
      chk(rd_fault === e_fault, e_tag, "rd_fault", 32'(rd_fault), 32'(e_fault));
      chk(rd_data === e_data, e_tag, "rd_data", rd_data, e_data);
    end
  end

  task automatic drive_idle();
    @(negedge clk);
    cmd_valid = 0; lk_valid = 0;
  endtask

  task automatic drive_look(input bit raw, input logic [31:0] a, input string tag);
    @(negedge clk);
    cur_req = tag; cmd_valid = 0;
    lk_valid = 1; lk_raw = raw; lk_addr = a;
  endtask

  task automatic drive_cmd(input bit unb, input int pg, input int cnt,
                           input logic [31:0] phys, input string tag);
    @(negedge clk);
    lk_valid = 0; cmd_valid = 0;
    while (!cmd_ready) @(negedge clk);
    cur_req = tag;
    cmd_valid = 1; cmd_unbind = unb; cmd_page = 19'(pg);
    cmd_count = 8'(cnt); cmd_phys = phys;
  endtask

  task automatic wait_ready();
    drive_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0; live = 1; cur_req = "R1";
    wait_ready();

    // R1 R2 R3: header and cleared entries
    drive_look(1, 0, "R2");
    drive_look(1, 1, "R3");
    drive_look(1, 2, "R1");
    drive_look(1, 40, "R1");
    drive_look(1, 65, "R1");
    drive_look(0, 32'h0000_0123, "R7");

    // R4 R6: bind host page 1, two host pages -> entries 2..5
    drive_cmd(0, 1, 2, 32'h8765_4ABC, "R4");
    wait_ready();
    drive_look(1, 4, "R4");
    drive_look(1, 5, "R4");
    drive_look(1, 7, "R4");
    drive_look(0, 32'h0000_2ABC, "R6");
    drive_look(0, 32'h0000_5FFF, "R6");
    drive_look(0, 32'h0000_4000, "R6");
    drive_look(0, 32'h0000_6000, "R7");

    // R10: lookups race the walker's writes
    drive_cmd(0, 10, 1, 32'h1111_1000, "R10");
    drive_look(0, 32'h0001_4123, "R10");
    drive_look(0, 32'h0001_5010, "R10");
    wait_ready();
    drive_look(0, 32'h0001_4123, "R10");
    drive_look(0, 32'h0001_5FFF, "R6");

    // R7 R8: out of range
    drive_look(0, 32'h0004_0000, "R7");
    drive_look(0, 32'hFFFF_FFFF, "R7");
    drive_look(0, 32'h0003_FFFF, "R7");
    drive_look(1, 66, "R8");
    drive_look(1, 32'h100, "R8");

    // R5: unbind, partial and never-bound
    drive_cmd(1, 1, 1, 32'hDEAD_0000, "R5");
    wait_ready();
    drive_look(0, 32'h0000_2000, "R5");
    drive_look(0, 32'h0000_3004, "R5");
    drive_look(0, 32'h0000_4010, "R5");
    drive_cmd(1, 20, 1, 32'h0, "R5");
    wait_ready();
    drive_look(1, 42, "R5");
    drive_look(1, 43, "R5");
    drive_look(0, 32'h0001_4000, "R5");

    // R11: zero count, clipping, start beyond table
    drive_cmd(0, 5, 0, 32'h2222_0000, "R11");
    drive_idle();
    drive_look(0, 32'h0000_A000, "R11");
    drive_cmd(0, 31, 4, 32'hABC0_0000, "R11");
    wait_ready();
    drive_look(1, 64, "R11");
    drive_look(1, 65, "R11");
    drive_look(0, 32'h0003_F123, "R11");
    drive_cmd(0, 40, 1, 32'h3333_0000, "R11");
    drive_idle();
    drive_look(1, 2, "R11");

    // R9: back-to-back and isolated lookups
    drive_look(0, 32'h0001_4FFF, "R9");
    drive_look(1, 0, "R9");
    drive_idle();
    drive_look(0, 32'h0003_E000, "R9");
    repeat (3) drive_idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule